// File: doc/BRIEF.md
# Weighted Normal Equation Accumulator

This block builds the 6x6 linear system that one Gauss-Newton pose-update step needs. Points arrive one data word per accepted cycle, seven words per point. For each point the block forms the six-term Jacobian of a photometric residual with respect to a small rigid-body motion. It then adds the weighted outer product of that row into a symmetric matrix, and the weighted residual times the row into a six-element vector. All arithmetic is signed two's-complement fixed point with FRAC fraction bits. The products are truncated toward minus infinity (an arithmetic right shift) and summed into wide accumulators.

Software or a sequencer writes the point count and pulses start. It then streams the words and waits for the done flag. After that it reads any matrix entry by row and column, and any vector entry by row, through combinational read ports. Only the upper triangle of the matrix is held. A read with row greater than column returns the mirrored entry.

Top module: `normal_eq_accum`

## Requirements
- R1: Each point is seven consecutive accepted words (in_valid_i high), in this order: x, y, z, gradient gx, gradient gy, weight w, residual r. Each word is a DW-bit signed value with FRAC fraction bits, and z must be positive.
- R2: Per point the block forms iz = floor(2^(2·FRAC) / z) with a divider that retires RADIX_BITS quotient bits per cycle. The result is ready 6 cycles after z is accepted with the defaults.
- R3: With m(a,b) = (a·b)>>>FRAC and s(a,b,c,d) = (a·b + c·d)>>>FRAC, let u = m(x,iz), v = m(y,iz), uu = m(u,u), vv = m(v,v), uv = m(u,v). The Jacobian terms are J0 = m(gx,iz), J1 = m(gy,iz), J2 = -s(u,J0,v,J1), J3 = -s(uv,gx,vv,gy) - gy, J4 = gx + s(uu,gx,uv,gy) and J5 = s(u,gy,-v,gx).
- R4: Points may follow back to back, so a new point starts every 7 cycles. No point's data or reciprocal is lost at that rate.
- R5: Per point, with q_k = m(w,J_k), every entry i≤j of the matrix gains m(q_i,J_j) and every vector entry i gains m(q_i,r). Accumulators are AW bits wide.
- R6: Matrix reads use rd_row_i and rd_col_i (0..5). A read with row > col returns entry (col,row). A row or column index of 6 or more reads 0 on rd_a_o. A row index of 6 or more reads 0 on rd_b_o.
- R7: A start_i pulse clears the matrix, the vector, the point count and the word position, and aborts any point in flight. npts_i is sampled on that pulse.
- R8: If the last point's z is accepted at edge Ez and its r at edge Er, done_o is high from edge max(Ez+7, Er)+2. It stays high until the next start. With npts_i = 0, done_o is high from the start edge.
- R9: Words offered before any start, or after all npts points' words have been accepted, are ignored.
- R10: Cycles with in_valid_i low may appear between any two words. They neither advance the word position nor change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear and begin a new accumulation |
| npts_i | input | CW | Number of points, sampled on start |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DW | Input word, signed fixed point |
| rd_row_i | input | 3 | Read row index |
| rd_col_i | input | 3 | Read column index |
| rd_a_o | output | AW | Matrix entry at (row, col), signed |
| rd_b_o | output | AW | Vector entry at row, signed |
| done_o | output | 1 | All points accumulated |

## Verification
The reciprocal is captured 7 edges after z is accepted. The Jacobian register loads one edge after both the reciprocal and the seven words are present, and the accumulators update on the following edge. done_o therefore rises at max(Ez+7, Er)+2. The bench records the edge on which each z and r word is sampled and derives this rise edge from those records. It compares done_o against that expectation 2 ns after every rising edge. The matrix and vector are read only after the expected done edge, through the combinational read ports, and sampled 1 ns after the address changes. Runs include back-to-back points, points with idle gaps, and a restart in the middle of a point.

// File: rtl/neq_pkg.sv
package neq_pkg;
  localparam int NJ    = 6;
  localparam int NTRI  = NJ * (NJ + 1) / 2;
  localparam int RW    = $clog2(NJ);
  localparam int TW    = $clog2(NTRI);

  typedef enum logic [2:0] {
    W_X  = 3'd0,
    W_Y  = 3'd1,
    W_Z  = 3'd2,
    W_GX = 3'd3,
    W_GY = 3'd4,
    W_W  = 3'd5,
    W_R  = 3'd6
  } word_e;

  // packed upper-triangle index, r <= c
  function automatic int tri_idx(input int r, input int c);
    return r * NJ - (r * (r - 1)) / 2 + (c - r);
  endfunction
endpackage

// File: rtl/neq_recip.sv
module neq_recip #(
  parameter int DW         = 16,
  parameter int FRAC       = 8,
  parameter int RADIX_BITS = 3,
  parameter int QW         = 2 * FRAC + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          abort_i,
  input  logic          start_i,
  input  logic [DW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o
);
  localparam int ITER = (QW + RADIX_BITS - 1) / RADIX_BITS;
  localparam int NW   = ITER * RADIX_BITS;
  localparam int CNTW = $clog2(ITER + 1);
  localparam logic [63:0]   NUM64 = 64'd1 << (2 * FRAC);
  localparam logic [NW-1:0] NUMER = NUM64[NW-1:0];

  logic            busy_q, done_q;
  logic [CNTW-1:0] cnt_q;
  logic [DW:0]     rem_q, rem_n;
  logic [NW-1:0]   num_q, num_n, quo_q, quo_n;
  logic [DW-1:0]   den_q;

  // RADIX_BITS restoring steps per cycle
  always_comb begin
    rem_n = rem_q;
    num_n = num_q;
    quo_n = quo_q;
    for (int k = 0; k < RADIX_BITS; k++) begin
      rem_n = {rem_n[DW-1:0], num_n[NW-1]};
      num_n = {num_n[NW-2:0], 1'b0};
      if (rem_n >= {1'b0, den_q}) begin
        rem_n = rem_n - {1'b0, den_q};
        quo_n = {quo_n[NW-2:0], 1'b1};
      end else begin
        quo_n = {quo_n[NW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNTW'(ITER);
        rem_q  <= '0;
        num_q  <= NUMER;
        quo_q  <= '0;
        den_q  <= den_i;
      end else if (busy_q) begin
        rem_q <= rem_n;
        num_q <= num_n;
        quo_q <= quo_n;
        cnt_q <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q[QW-1:0];

  assert_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);

  assert_quotient_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && den_q != '0) |->
      ((64'(quo_o) * 64'(den_q) <= NUM64) && ((64'(quo_o) + 64'd1) * 64'(den_q) > NUM64)));
endmodule

// File: rtl/neq_jacobian.sv
module neq_jacobian import neq_pkg::*; #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int QW   = 2 * FRAC + 2,
  parameter int JW   = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] gx_i,
  input  logic signed [DW-1:0] gy_i,
  input  logic signed [DW-1:0] w_i,
  input  logic signed [DW-1:0] r_i,
  input  logic [QW-1:0]        iz_i,
  output logic                 vld_o,
  output logic signed [JW-1:0] j_o  [NJ],
  output logic signed [JW-1:0] wj_o [NJ],
  output logic signed [JW-1:0] r_o
);
  localparam int PW = 2 * JW;

  function automatic logic signed [JW-1:0] fmul(input logic signed [JW-1:0] a,
                                                input logic signed [JW-1:0] b);
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b);
    return JW'(p >>> FRAC);
  endfunction

  function automatic logic signed [JW-1:0] fdot(input logic signed [JW-1:0] a,
                                                input logic signed [JW-1:0] b,
                                                input logic signed [JW-1:0] c,
                                                input logic signed [JW-1:0] d);
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b) + PW'(c) * PW'(d);
    return JW'(p >>> FRAC);
  endfunction

  logic signed [JW-1:0] xe, ye, gxe, gye, we, re, ize;
  logic signed [JW-1:0] u, v, nv, uu, vv, uv;
  logic signed [JW-1:0] jac [NJ];
  logic signed [JW-1:0] wj  [NJ];

  assign xe  = JW'(x_i);
  assign ye  = JW'(y_i);
  assign gxe = JW'(gx_i);
  assign gye = JW'(gy_i);
  assign we  = JW'(w_i);
  assign re  = JW'(r_i);
  assign ize = JW'($signed({1'b0, iz_i}));

  assign u  = fmul(xe, ize);
  assign v  = fmul(ye, ize);
  assign nv = -v;
  assign uu = fmul(u, u);
  assign vv = fmul(v, v);
  assign uv = fmul(u, v);

  assign jac[0] = fmul(gxe, ize);
  assign jac[1] = fmul(gye, ize);
  assign jac[2] = -fdot(u, jac[0], v, jac[1]);
  assign jac[3] = -fdot(uv, gxe, vv, gye) - gye;
  assign jac[4] = gxe + fdot(uu, gxe, uv, gye);
  assign jac[5] = fdot(u, gye, nv, gxe);

  for (genvar k = 0; k < NJ; k++) begin : g_wj
    assign wj[k] = fmul(we, jac[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      r_o   <= '0;
      for (int k = 0; k < NJ; k++) begin
        j_o[k]  <= '0;
        wj_o[k] <= '0;
      end
    end else begin
      vld_o <= fire_i;
      if (fire_i) begin
        r_o <= re;
        for (int k = 0; k < NJ; k++) begin
          j_o[k]  <= jac[k];
          wj_o[k] <= wj[k];
        end
      end
    end
  end
endmodule

// File: rtl/neq_store.sv
module neq_store import neq_pkg::*; #(
  parameter int FRAC = 8,
  parameter int JW   = 32,
  parameter int AW   = 48
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 acc_i,
  input  logic signed [JW-1:0] j_i  [NJ],
  input  logic signed [JW-1:0] wj_i [NJ],
  input  logic signed [JW-1:0] r_i,
  input  logic [RW-1:0]        rd_row_i,
  input  logic [RW-1:0]        rd_col_i,
  output logic signed [AW-1:0] rd_a_o,
  output logic signed [AW-1:0] rd_b_o
);
  localparam int PW = 2 * JW;
  localparam logic [RW-1:0] NJR = RW'(NJ);

  logic signed [AW-1:0] a_flat [NTRI];
  logic signed [AW-1:0] b_flat [NJ];

  for (genvar i = 0; i < NJ; i++) begin : g_row
    for (genvar c = i; c < NJ; c++) begin : g_col
      localparam int T = tri_idx(i, c);
      logic signed [PW-1:0] pa;
      logic signed [AW-1:0] acc_q;
      assign pa = PW'(wj_i[i]) * PW'(j_i[c]);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     acc_q <= '0;
        else if (clr_i)  acc_q <= '0;
        else if (acc_i)  acc_q <= acc_q + AW'(pa >>> FRAC);
      end
      assign a_flat[T] = acc_q;
    end

    logic signed [PW-1:0] pb;
    logic signed [AW-1:0] bacc_q;
    assign pb = PW'(wj_i[i]) * PW'(r_i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bacc_q <= '0;
      else if (clr_i)  bacc_q <= '0;
      else if (acc_i)  bacc_q <= bacc_q + AW'(pb >>> FRAC);
    end
    assign b_flat[i] = bacc_q;
  end

  logic [RW-1:0] lo, hi;
  logic [TW-1:0] ti;

  // lower-triangle reads fold onto the stored upper entry
  always_comb begin
    lo     = (rd_row_i <= rd_col_i) ? rd_row_i : rd_col_i;
    hi     = (rd_row_i <= rd_col_i) ? rd_col_i : rd_row_i;
    ti     = TW'(tri_idx(int'(lo), int'(hi)));
    rd_a_o = '0;
    rd_b_o = '0;
    if (rd_row_i < NJR && rd_col_i < NJR) rd_a_o = a_flat[ti];
    if (rd_row_i < NJR)                   rd_b_o = b_flat[rd_row_i];
  end

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (a_flat[0] == '0 && a_flat[NTRI-1] == '0 && b_flat[0] == '0));

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !acc_i) |=> ($stable(a_flat[0]) && $stable(b_flat[NJ-1])));
endmodule

// File: rtl/normal_eq_accum.sv
module normal_eq_accum import neq_pkg::*; #(
  parameter int DW         = 16,
  parameter int FRAC       = 8,
  parameter int JW         = 32,
  parameter int AW         = 48,
  parameter int CW         = 16,
  parameter int RADIX_BITS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] npts_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic [RW-1:0] rd_row_i,
  input  logic [RW-1:0] rd_col_i,
  output logic [AW-1:0] rd_a_o,
  output logic [AW-1:0] rd_b_o,
  output logic          done_o
);
  localparam int QW = 2 * FRAC + 2;

  logic                 active_q, done_q, snap_ok_q, iz_ok_q;
  word_e                widx_q;
  logic [CW-1:0]        npts_q, recv_q, pts_done_q;
  logic signed [DW-1:0] x_c, y_c, gx_c, gy_c, w_c;
  logic signed [DW-1:0] x_h, y_h, gx_h, gy_h, w_h, r_h;
  logic [QW-1:0]        iz_q, div_quo;
  logic                 take, div_go, div_done, fire, jac_vld;
  logic signed [JW-1:0] jac_j  [NJ];
  logic signed [JW-1:0] jac_wj [NJ];
  logic signed [JW-1:0] jac_r;

  assign take   = in_valid_i && active_q && !start_i;
  assign div_go = take && (widx_q == W_Z);
  assign fire   = snap_ok_q && iz_ok_q && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      done_q     <= 1'b0;
      snap_ok_q  <= 1'b0;
      iz_ok_q    <= 1'b0;
      widx_q     <= W_X;
      npts_q     <= '0;
      recv_q     <= '0;
      pts_done_q <= '0;
      iz_q       <= '0;
      {x_c, y_c, gx_c, gy_c, w_c}      <= '0;
      {x_h, y_h, gx_h, gy_h, w_h, r_h} <= '0;
    end else if (start_i) begin
      active_q   <= (npts_i != '0);
      done_q     <= (npts_i == '0);
      snap_ok_q  <= 1'b0;
      iz_ok_q    <= 1'b0;
      widx_q     <= W_X;
      npts_q     <= npts_i;
      recv_q     <= '0;
      pts_done_q <= '0;
    end else begin
      if (fire) begin
        snap_ok_q <= 1'b0;
        iz_ok_q   <= 1'b0;
      end
      if (div_done) begin
        iz_q    <= div_quo;
        iz_ok_q <= 1'b1;
      end
      if (take) begin
        case (widx_q)
          W_X:     x_c  <= $signed(in_data_i);
          W_Y:     y_c  <= $signed(in_data_i);
          W_GX:    gx_c <= $signed(in_data_i);
          W_GY:    gy_c <= $signed(in_data_i);
          W_W:     w_c  <= $signed(in_data_i);
          default: ;
        endcase
        if (widx_q == W_R) begin
          {x_h, y_h, gx_h, gy_h, w_h} <= {x_c, y_c, gx_c, gy_c, w_c};
          r_h       <= $signed(in_data_i);
          snap_ok_q <= 1'b1;
          widx_q    <= W_X;
          recv_q    <= recv_q + CW'(1);
          if (recv_q + CW'(1) == npts_q) active_q <= 1'b0;
        end else begin
          widx_q <= word_e'(widx_q + 3'd1);
        end
      end
      if (jac_vld) begin
        pts_done_q <= pts_done_q + CW'(1);
        if (pts_done_q + CW'(1) == npts_q) done_q <= 1'b1;
      end
    end
  end

  neq_recip #(.DW(DW), .FRAC(FRAC), .RADIX_BITS(RADIX_BITS), .QW(QW)) u_recip (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (start_i),
    .start_i (div_go),
    .den_i   (in_data_i),
    .done_o  (div_done),
    .quo_o   (div_quo)
  );

  neq_jacobian #(.DW(DW), .FRAC(FRAC), .QW(QW), .JW(JW)) u_jac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .x_i    (x_h),
    .y_i    (y_h),
    .gx_i   (gx_h),
    .gy_i   (gy_h),
    .w_i    (w_h),
    .r_i    (r_h),
    .iz_i   (iz_q),
    .vld_o  (jac_vld),
    .j_o    (jac_j),
    .wj_o   (jac_wj),
    .r_o    (jac_r)
  );

  neq_store #(.FRAC(FRAC), .JW(JW), .AW(AW)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .acc_i    (jac_vld),
    .j_i      (jac_j),
    .wj_i     (jac_wj),
    .r_i      (jac_r),
    .rd_row_i (rd_row_i),
    .rd_col_i (rd_col_i),
    .rd_a_o   (rd_a_o),
    .rd_b_o   (rd_b_o)
  );

  assign done_o = done_q;

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pts_done_q <= npts_q);

  assert_idle_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_q && !start_i) |=> ($stable(widx_q) && $stable(recv_q)));

  assert_word_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && widx_q == W_R) |=> (widx_q == W_X && snap_ok_q));
endmodule

// File: tb/normal_eq_accum_tb_top.sv
module normal_eq_accum_tb_top;
  localparam int DW   = 16;
  localparam int FRAC = 8;
  localparam int AW   = 48;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] npts = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [2:0]    rd_row = '0, rd_col = '0;
  logic [AW-1:0] rd_a, rd_b;
  logic          done;

  int  cyc = 0;
  int  n_chk = 0, n_fail = 0;
  int  exp_done_edge = -1;
  int  npts_exp = 0, pts_sent = 0;
  bit  finished = 1'b0;
  longint exp_a [6][6];
  longint exp_b [6];

  normal_eq_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .npts_i(npts),
    .in_valid_i(in_valid), .in_data_i(in_data),
    .rd_row_i(rd_row), .rd_col_i(rd_col),
    .rd_a_o(rd_a), .rd_b_o(rd_b), .done_o(done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  function automatic longint fm(longint a, longint b);
    return (a * b) >>> FRAC;
  endfunction
  function automatic longint fd(longint a, longint b, longint c, longint d);
    return (a * b + c * d) >>> FRAC;
  endfunction

  task automatic check(string tag, longint act, longint expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // done_o compared after every edge against the predicted rise edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished)
      check("R8 done timing", longint'(done),
            longint'(exp_done_edge >= 0 && cyc >= exp_done_edge));
  end

  task automatic model_clear();
    for (int i = 0; i < 6; i++) begin
      exp_b[i] = 0;
      for (int j = 0; j < 6; j++) exp_a[i][j] = 0;
    end
  endtask

  task automatic do_start(int n);
    @(negedge clk);
    start = 1'b1; npts = CW'(n); in_valid = 1'b0;
    exp_done_edge = (n == 0) ? cyc + 1 : -1;
    npts_exp = n; pts_sent = 0;
    model_clear();
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic send_word(longint v, output int e);
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(v);
    e = cyc + 1;
  endtask

  task automatic send_point(longint x, longint y, longint z, longint gx, longint gy,
                            longint w, longint r, int gap, bit counted);
    longint wd [7];
    longint iz, u, v, uu, vv, uv;
    longint jj [6];
    longint q [6];
    int e, ez, er;
    wd = '{x, y, z, gx, gy, w, r};
    ez = 0; er = 0;
    for (int k = 0; k < 7; k++) begin
      if (k > 0 && gap > 0) idle(gap);
      send_word(wd[k], e);
      if (k == 2) ez = e;
      if (k == 6) er = e;
    end
    if (!counted) return;
    iz = (64'sd1 <<< (2 * FRAC)) / z;
    u = fm(x, iz); v = fm(y, iz);
    uu = fm(u, u); vv = fm(v, v); uv = fm(u, v);
    jj[0] = fm(gx, iz);
    jj[1] = fm(gy, iz);
    jj[2] = -fd(u, jj[0], v, jj[1]);
    jj[3] = -fd(uv, gx, vv, gy) - gy;
    jj[4] = gx + fd(uu, gx, uv, gy);
    jj[5] = fd(u, gy, -v, gx);
    for (int i = 0; i < 6; i++) q[i] = fm(w, jj[i]);
    for (int i = 0; i < 6; i++) begin
      exp_b[i] += fm(q[i], r);
      for (int j = i; j < 6; j++) begin
        exp_a[i][j] += fm(q[i], jj[j]);
        if (j != i) exp_a[j][i] = exp_a[i][j];
      end
    end
    pts_sent++;
    if (pts_sent == npts_exp)
      exp_done_edge = ((ez + 7 > er) ? ez + 7 : er) + 2;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        rd_row = 3'(i); rd_col = 3'(j);
        #1;
        check($sformatf("%s A[%0d][%0d]", tag, i, j), longint'($signed(rd_a)), exp_a[i][j]);
      end
      check($sformatf("%s b[%0d]", tag, i), longint'($signed(rd_b)), exp_b[i]);
    end
  endtask

  initial begin
    int e;
    repeat (3) @(negedge clk);
    #1;
    check("R7 reset done", longint'(done), 0);
    check("R7 reset A", longint'($signed(rd_a)), 0);
    rst_n = 1'b1;
    idle(2);

    // words before any start are ignored
    send_word(256, e); send_word(256, e); send_word(256, e);
    idle(8);
    check("R9 pre-start A", longint'($signed(rd_a)), 0);

    // empty run
    do_start(0);
    idle(3);

    // single point
    do_start(1);
    send_point(256, -128, 512, 768, -320, 256, 192, 0, 1'b1);
    idle(6);
    check_all("R1/R2/R3/R5/R6 single");

    // back-to-back points at the 7-cycle rate
    do_start(4);
    send_point(256, -128, 512, 768, -320, 256, 192, 0, 1'b1);
    send_point(-512, 384, 256, -640, 1024, 128, -384, 0, 1'b1);
    send_point(77, 230, 947, 282, 154, 448, 563, 0, 1'b1);
    send_point(768, -768, 1280, -1792, -1536, 512, -768, 0, 1'b1);
    idle(6);
    check_all("R4/R5 burst");

    // idle gaps between words, then surplus words after the count
    do_start(2);
    send_point(77, 230, 947, 282, 154, 448, 563, 2, 1'b1);
    send_point(-512, 384, 256, -640, 1024, 128, -384, 3, 1'b1);
    idle(8);
    check_all("R10 gaps");
    send_point(999, 999, 300, 999, 999, 999, 999, 0, 1'b0);
    idle(12);
    check_all("R9 surplus");
    @(negedge clk);
    rd_row = 3'd6; rd_col = 3'd1; #1;
    check("R6 row out of range A", longint'($signed(rd_a)), 0);
    check("R6 row out of range b", longint'($signed(rd_b)), 0);
    @(negedge clk);
    rd_row = 3'd2; rd_col = 3'd7; #1;
    check("R6 col out of range A", longint'($signed(rd_a)), 0);

    // restart in the middle of a point
    do_start(2);
    send_word(256, e); send_word(-128, e); send_word(512, e); send_word(768, e);
    do_start(1);
    idle(2);
    check_all("R7 clear");
    send_point(768, -768, 1280, -1792, -1536, 512, -768, 0, 1'b1);
    idle(10);
    check_all("R7 restart");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog R8: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule